// File: doc/BRIEF.md
# Two-Channel Converter Code Staging Controller

This block is the digital front end of a two-channel digital-to-analog converter. Each channel keeps a staging register that software loads and an output register whose 12-bit code drives the analog converter. Software never writes the output register. It writes sample words through a simple write port. A write names the target channel, or both channels at once, and one of three alignment formats. A write may carry one channel's value or pack both channels into one 32-bit word.

Each channel chooses how its staged value reaches the output. With triggering off, a write goes straight through to the output. With triggering on, the value waits for a trigger event. The event comes from a software trigger pulse or from one of several asynchronous external trigger lines, which are synchronised and edge-detected. After a triggered transfer, a channel with DMA enabled raises a request. The request stays up until the next accepted write to that channel's staging register.

Top module: `dac_stage_ctrl`

## Requirements
- R1: After reset, both output codes are 0, both DMA requests are low and both software-trigger pending bits are low.
- R2: The write format is wr_fmt. Value 0 means 12-bit right-aligned, and the code is data bits 11:0. Value 1 means 12-bit left-aligned, and the code is data bits 15:4. Value 2 means 8-bit, and the code is data bits 7:0 followed by four zero bits.
- R3: wr_chan bit 0 selects channel A and bit 1 selects channel B. When both bits are set, the write is a dual write. In a dual 8-bit write, A takes bits 7:0 and B takes bits 15:8. In a dual 12-bit write, A uses the low half-word and B uses the high half-word (bits 31:16), with the same alignment for both. A single-channel write always uses the low half-word.
- R4: On an enabled channel with triggering off, a write appears on the output code at the clock edge that accepts it.
- R5: On an enabled channel with triggering on, the output code changes only on a trigger transfer. The transfer loads the value staged before that edge, even if a write is accepted at the same edge.
- R6: A sw_trig pulse on an enabled channel sets that channel's pending bit at the next edge. The hardware clears the bit one edge later, and when the channel selects software triggering the transfer happens at that same edge.
- R7: An external trigger line passes two synchroniser stages and an edge detector. The output changes at the third clock edge after the line rises, and a line held high causes exactly one transfer.
- R8: The trigger select value 0 chooses the software trigger, and value k from 1 to NUM_EXT chooses ext_trig[k-1]. Sources that are not selected have no effect on the output.
- R9: A triggered transfer on a channel with dma_en set raises that channel's dma_req at the same edge. The request stays high until an accepted write to that channel. A write that goes straight through never raises it.
- R10: A disabled channel drives code 0 and dma_req low, and it makes no transfers. Its staging register still accepts writes.
- R11: A write with wr_fmt = 3 or wr_chan = 0 is ignored. It changes no staging register, no output code and no DMA request.
- R12: Two channels that select the same external trigger line both transfer at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_chan | input | 2 | Target channel mask (bit 0 = A, bit 1 = B) |
| wr_fmt | input | 2 | Alignment format (0 R12, 1 L12, 2 R8, 3 reserved) |
| wr_data | input | 32 | Write data word |
| chan_en | input | 2 | Per-channel enable |
| trig_en | input | 2 | Per-channel trigger mode enable |
| dma_en | input | 2 | Per-channel DMA request enable |
| trig_sel_a | input | SEL_W | Trigger source for channel A |
| trig_sel_b | input | SEL_W | Trigger source for channel B |
| sw_trig | input | 2 | Software trigger pulse per channel |
| ext_trig | input | NUM_EXT | Asynchronous external trigger lines |
| sw_pend | output | 2 | Software trigger pending bits |
| code_a | output | 12 | Channel A converter code |
| code_b | output | 12 | Channel B converter code |
| dma_req | output | 2 | Per-channel DMA request |

## Verification
The bench sweeps every format over many data words, for single and dual writes, and compares each result with slicing arithmetic of its own. A design that swaps lanes or mis-aligns a format would show the wrong code. It accepts a write at the same edge as a software-triggered transfer, which catches a design that forwards the fresh write instead of the staged value. It holds an external line high across many cycles, where a level-sensitive design would keep transferring, and it samples one edge before the expected transfer to catch a missing or extra synchroniser stage. It also checks that a reserved-format write leaves a pending DMA request in place and that a straight-through write never raises one, both of which a loose request decoder would get wrong.

// File: rtl/dac_stage_pkg.sv
package dac_stage_pkg;

  localparam int CODE_W = 12;
  localparam int LANE_W = 16;

  typedef enum logic [1:0] {
    FMT_R12 = 2'd0,
    FMT_L12 = 2'd1,
    FMT_R8  = 2'd2,
    FMT_RSV = 2'd3
  } wfmt_e;

  // Pick the 16-bit lane that carries one channel's value.
  function automatic logic [LANE_W-1:0] lane_pick(input logic [1:0] fmt,
                                                  input logic [2*LANE_W-1:0] d,
                                                  input logic dual,
                                                  input logic hi);
    logic [LANE_W-1:0] r;
    if (!dual)
      r = d[LANE_W-1:0];
    else if (fmt == FMT_R8)
      r = hi ? {8'h00, d[15:8]} : {8'h00, d[7:0]};
    else
      r = hi ? d[2*LANE_W-1:LANE_W] : d[LANE_W-1:0];
    return r;
  endfunction

  // Convert one lane into a converter code according to alignment.
  function automatic logic [CODE_W-1:0] lane_code(input logic [1:0] fmt,
                                                  input logic [LANE_W-1:0] lane);
    logic [CODE_W-1:0] c;
    case (fmt)
      FMT_R12: c = lane[CODE_W-1:0];
      FMT_L12: c = lane[LANE_W-1:LANE_W-CODE_W];
      FMT_R8:  c = {lane[7:0], 4'h0};
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dac_ext_sync.sv
module dac_ext_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  output logic [N-1:0] rise
);
  logic [N-1:0] stg [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= lines;
      for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign rise = stg[STAGES-1] & ~stg[STAGES];

  // R7
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/dac_trig_src.sv
module dac_trig_src #(
  parameter int NUM_EXT = 3,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tr_en,
  input  logic [SEL_W-1:0]   sel,
  input  logic               sw_set,
  input  logic [NUM_EXT-1:0] ext_rise,
  output logic               sw_pend,
  output logic               fire
);
  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_pend <= 1'b0;
    else        sw_pend <= sw_set & en;
  end

  always_comb begin
    hit = 1'b0;
    if (sel == '0) hit = sw_pend;
    for (int k = 0; k < NUM_EXT; k++)
      if (sel == SEL_W'(k + 1)) hit = ext_rise[k];
  end

  assign fire = en & tr_en & hit;

  // R6
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pend && !sw_set) |=> !sw_pend);
  // R10
  off_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !fire);
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_stage_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tr_en,
  input  logic              dma_en,
  input  logic              wr_hit,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              fire,
  output logic [CODE_W-1:0] code,
  output logic              dma_req,
  output logic              direct_load
);
  logic [CODE_W-1:0] hold;

  assign direct_load = en & wr_hit & ~tr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= '0;
    else if (wr_hit) hold <= wr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code    <= '0;
      dma_req <= 1'b0;
    end else if (!en) begin
      code    <= '0;
      dma_req <= 1'b0;
    end else begin
      if (fire)             code <= hold;
      else if (direct_load) code <= wr_code;
      if (fire && dma_en)   dma_req <= 1'b1;
      else if (wr_hit)      dma_req <= 1'b0;
    end
  end

  // R5
  hold_until_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tr_en && !fire) |=> $stable(code));
  // R4
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    direct_load |=> (code == $past(wr_code)));
  // R9
  dma_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dma_en) |=> dma_req);
  // R9
  dma_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && en && !wr_hit) |=> dma_req);
  // R10
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (code == '0 && !dma_req));
endmodule

// File: rtl/dac_stage_ctrl.sv
module dac_stage_ctrl
  import dac_stage_pkg::*;
#(
  parameter int NUM_EXT     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(NUM_EXT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_chan,
  input  logic [1:0]         wr_fmt,
  input  logic [31:0]        wr_data,
  input  logic [1:0]         chan_en,
  input  logic [1:0]         trig_en,
  input  logic [1:0]         dma_en,
  input  logic [SEL_W-1:0]   trig_sel_a,
  input  logic [SEL_W-1:0]   trig_sel_b,
  input  logic [1:0]         sw_trig,
  input  logic [NUM_EXT-1:0] ext_trig,
  output logic [1:0]         sw_pend,
  output logic [CODE_W-1:0]  code_a,
  output logic [CODE_W-1:0]  code_b,
  output logic [1:0]         dma_req
);
  localparam int NCH = 2;

  logic               fmt_ok, dual;
  logic [NUM_EXT-1:0] ext_rise;
  logic [SEL_W-1:0]   sel    [NCH];
  logic [CODE_W-1:0]  wcode  [NCH];
  logic [CODE_W-1:0]  ocode  [NCH];
  logic [NCH-1:0]     wr_hit, fire, direct_load;

  assign fmt_ok = (wr_fmt != FMT_RSV);
  assign dual   = &wr_chan;
  assign sel[0] = trig_sel_a;
  assign sel[1] = trig_sel_b;

  dac_ext_sync #(.N(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .lines(ext_trig), .rise(ext_rise));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign wr_hit[c] = wr_en & fmt_ok & wr_chan[c];
    assign wcode[c]  = lane_code(wr_fmt, lane_pick(wr_fmt, wr_data, dual, c != 0));

    dac_trig_src #(.NUM_EXT(NUM_EXT), .SEL_W(SEL_W)) u_trig (
      .clk(clk), .rst_n(rst_n), .en(chan_en[c]), .tr_en(trig_en[c]),
      .sel(sel[c]), .sw_set(sw_trig[c]), .ext_rise(ext_rise),
      .sw_pend(sw_pend[c]), .fire(fire[c]));

    dac_chan u_chan (
      .clk(clk), .rst_n(rst_n), .en(chan_en[c]), .tr_en(trig_en[c]),
      .dma_en(dma_en[c]), .wr_hit(wr_hit[c]), .wr_code(wcode[c]),
      .fire(fire[c]), .code(ocode[c]), .dma_req(dma_req[c]),
      .direct_load(direct_load[c]));
  end

  assign code_a = ocode[0];
  assign code_b = ocode[1];

  // R11
  rsv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fmt_ok) |-> (wr_hit == '0));
  // R12
  same_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&chan_en && &trig_en && sel[0] == sel[1] && sel[0] != '0) |-> (fire[0] == fire[1]));
  // R9
  no_direct_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_load[0] && !dma_req[0]) |=> !dma_req[0]);
endmodule

// File: tb/test_dac_stage_ctrl.sv
module test_dac_stage_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_chan = '0, wr_fmt = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  chan_en = '0, trig_en = '0, dma_en = '0, sw_trig = '0;
  logic [1:0]  trig_sel_a = '0, trig_sel_b = '0;
  logic [2:0]  ext_trig = '0;
  logic [1:0]  sw_pend, dma_req;
  logic [11:0] code_a, code_b;
  int checks = 0, errors = 0;
  logic [11:0] ea, eb;

  always #2.5 clk = ~clk;

  dac_stage_ctrl i_dac_stage_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_fmt(wr_fmt),
    .wr_data(wr_data), .chan_en(chan_en), .trig_en(trig_en), .dma_en(dma_en),
    .trig_sel_a(trig_sel_a), .trig_sel_b(trig_sel_b), .sw_trig(sw_trig),
    .ext_trig(ext_trig), .sw_pend(sw_pend), .code_a(code_a), .code_b(code_b),
    .dma_req(dma_req));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] ch, logic [1:0] fmt, logic [31:0] d);
    wr_en = 1'b1; wr_chan = ch; wr_fmt = fmt; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  function automatic logic [11:0] exp_code(logic [1:0] fmt, logic [31:0] d, bit hi, bit dual);
    logic [31:0] v;
    v = (dual && hi) ? ((fmt == 2) ? (d >> 8) : (d >> 16)) : d;
    case (fmt)
      0: return v[11:0];
      1: return 12'((v >> 4) & 32'hfff);
      2: return 12'((v & 32'hff) * 16);
      default: return 12'h0;
    endcase
  endfunction

  task automatic sw_fire_a();
    sw_trig = 2'b01; tick(1); sw_trig = 2'b00; tick(1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    // R1 reset state
    check("R1 code_a", code_a, 0);
    check("R1 code_b", code_b, 0);
    check("R1 dma", dma_req, 0);
    check("R1 pend", sw_pend, 0);
    rst_n = 1'b1; chan_en = 2'b11; tick(1);

    // R2 R4 single writes, all formats, direct mode
    for (int f = 0; f < 3; f++)
      for (int v = 0; v < 64; v++) begin
        logic [31:0] d;
        d = 32'(v * 32'h9E3779B1) ^ 32'(v << 7);
        wr(2'b01, 2'(f), d);
        check("R2 R4 single A", code_a, exp_code(2'(f), d, 0, 0));
        wr(2'b10, 2'(f), ~d);
        check("R2 single B low lane", code_b, exp_code(2'(f), ~d, 1, 0));
      end
    // R3 dual writes
    for (int f = 0; f < 3; f++)
      for (int v = 0; v < 64; v++) begin
        logic [31:0] d;
        d = 32'(v * 32'h7F4A7C15) + 32'(v);
        wr(2'b11, 2'(f), d);
        check("R3 dual A", code_a, exp_code(2'(f), d, 0, 1));
        check("R3 dual B", code_b, exp_code(2'(f), d, 1, 1));
      end

    // R11 ignored writes
    wr(2'b11, 2'd0, 32'h0123_0456);
    wr(2'b11, 2'd3, 32'hFFFF_FFFF);
    check("R11 rsv fmt A", code_a, 12'h456);
    check("R11 rsv fmt B", code_b, 12'h123);
    wr(2'b00, 2'd0, 32'h0000_0777);
    check("R11 empty mask A", code_a, 12'h456);

    // R5 R6 software trigger on A
    trig_en = 2'b01; trig_sel_a = 2'd0; dma_en = 2'b11;
    wr(2'b01, 2'd0, 32'h0000_0ABC);
    check("R5 no transfer before trigger", code_a, 12'h456);
    sw_trig = 2'b01; tick(1); sw_trig = 2'b00;
    check("R6 pend set", sw_pend, 2'b01);
    check("R6 code not yet", code_a, 12'h456);
    tick(1);
    check("R6 transfer", code_a, 12'hABC);
    check("R6 pend cleared", sw_pend, 2'b00);
    check("R9 dma raised", dma_req, 2'b01);
    tick(4);
    check("R9 dma held", dma_req, 2'b01);
    wr(2'b01, 2'd3, 32'h0000_0111);
    check("R11 rsv keeps dma", dma_req, 2'b01);
    // R5 write accepted at the trigger edge: old staged value transfers
    wr(2'b01, 2'd0, 32'h0000_0321);
    check("R9 dma cleared by write", dma_req, 2'b00);
    sw_trig = 2'b01; tick(1); sw_trig = 2'b00;
    wr(2'b01, 2'd0, 32'h0000_0654);
    check("R5 same-edge uses staged", code_a, 12'h321);
    check("R9 same-edge set wins", dma_req, 2'b01);
    sw_fire_a();
    check("R5 next trigger", code_a, 12'h654);
    // R9 direct write on B never raises a request
    wr(2'b10, 2'd0, 32'h0000_0999);
    check("R9 direct no dma", dma_req[1], 1'b0);
    check("R4 direct B", code_b, 12'h999);

    // R7 external line 1 on A, long pulse
    trig_sel_a = 2'd2;
    wr(2'b01, 2'd0, 32'h0000_0A5A);
    ext_trig = 3'b010; tick(2);
    check("R7 not before third edge", code_a, 12'h654);
    tick(1);
    check("R7 third edge", code_a, 12'hA5A);
    wr(2'b01, 2'd0, 32'h0000_05A5);
    tick(10);
    check("R7 held line one transfer", code_a, 12'hA5A);
    ext_trig = 3'b000; tick(2);
    // R8 other sources ignored
    ext_trig = 3'b101; sw_trig = 2'b01; tick(1); sw_trig = 2'b00; tick(5);
    check("R8 unselected ignored", code_a, 12'hA5A);
    ext_trig = 3'b000; tick(2);
    ext_trig = 3'b010; tick(3);
    check("R7 second rise", code_a, 12'h5A5);
    ext_trig = 3'b000; tick(2);

    // R12 shared source on both channels
    trig_en = 2'b11; trig_sel_a = 2'd3; trig_sel_b = 2'd3;
    wr(2'b11, 2'd1, 32'h1230_4560);
    ext_trig = 3'b100; tick(2);
    check("R12 A old", code_a, 12'h5A5);
    check("R12 B old", code_b, 12'h999);
    tick(1);
    check("R12 A new", code_a, 12'h456);
    check("R12 B new", code_b, 12'h123);
    ext_trig = 3'b000; tick(2);

    // R10 disabled channel
    chan_en = 2'b10; tick(1);
    check("R10 code zero", code_a, 0);
    check("R10 dma low", dma_req[0], 1'b0);
    wr(2'b01, 2'd0, 32'h0000_0777);
    ext_trig = 3'b100; tick(4);
    check("R10 no transfer", code_a, 0);
    ext_trig = 3'b000; chan_en = 2'b11; tick(2);
    check("R10 stays zero on enable", code_a, 0);
    ext_trig = 3'b100; tick(3);
    check("R10 staged write kept", code_a, 12'h777);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule